// File: doc/BRIEF.md
# UART Sampling-Rate Generator with Selectable Prescaler

This block turns a reference clock into a single-cycle enable that fires sixteen times per serial bit. A UART transmitter uses the enable to shift bits and a receiver uses it to sample the line. A second output fires once per bit time, on every sixteenth sampling enable. The rate is set by two stages. The first is a prescaler that passes every reference cycle or one cycle in four. The second is a 16-bit divisor that counts prescaled cycles.

Software reaches the block through a plain write port with a 2-bit select. Two selects load the divisor bytes, one selects the prescaler, and one is unused. Each write that changes the configuration restarts the counting chain from its start state, so no partial count from the old setting leaks into the new rate. A divisor of zero behaves as a divisor of one, so the enables never stop. As an example, a 14.7456 MHz reference with divisor 0x0900 gives 400 bit/s when the prescaler passes every cycle and 100 bit/s when it divides by four. Divisor 1 gives 921.6 kbit/s and 230.4 kbit/s respectively.

Top module: `uart_rate_gen`

## Requirements
- R1: While `rst_n` is low, both enables are low. Reset sets the divisor to 1 and the prescaler to divide-by-1. From the first rising edge with `rst_n` high, `samp_en` is therefore high every cycle and `bit_en` is high on every 16th cycle.
- R2: A write with `wr_sel` = 0 loads `wr_data` into divisor bits 7:0. A write with `wr_sel` = 1 loads divisor bits 15:8. A write with `wr_sel` = 2 sets the prescaler from `wr_data` bit 7 (1 selects divide-by-4, 0 selects divide-by-1) and ignores the other data bits. A write with `wr_sel` = 3 changes nothing and does not restart the counting.
- R3: With divide-by-1 and a divisor D ≥ 1, `samp_en` is high for one cycle out of every D cycles.
- R4: With divide-by-4 and a divisor D ≥ 1, `samp_en` is high for one cycle out of every 4·D cycles.
- R5: A divisor of 0 gives the same output as a divisor of 1.
- R6: `bit_en` is high only in cycles where `samp_en` is high, and it is high on every 16th `samp_en` pulse counted from a restart.
- R7: A write with `wr_sel` 0, 1 or 2 is captured at rising edge t and restarts the counting at edge t+1. Both enables are low after edge t+1. With period P·D, the first `samp_en` follows edge t+1+P·D, and the first `bit_en` follows edge t+1+16·P·D.
- R8: When the period P·D is greater than 1, `samp_en` never stays high for two cycles in a row.
- R9: The divisor uses all 16 bits. For example, 0x0102 gives a period of 258 cycles and 0x0100 gives a period of 256 cycles. A zero low byte under a non-zero high byte is not treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 divisor low byte, 1 divisor high byte, 2 prescaler mode, 3 unused |
| wr_data | input | 8 | Write data |
| samp_en | output | 1 | Enable at 16 times the bit rate, one cycle wide |
| bit_en | output | 1 | Enable at the bit rate, coincident with every 16th samp_en |

## Verification
Two things can fall in the same cycle. A configuration write can land on the edge where the divisor counter reloads and emits a pulse. The sampling pulse and the bit pulse are also due on the same edge. The bench provokes the first collision by writing at each phase offset of a short running period, including the reload edge itself. It then requires that the restart wins: both outputs are low after the load edge, and the next pulse appears exactly P·D cycles later. The second collision is judged every cycle by an arithmetic model that counts edges since the last restart. The model expects a pulse when the count is a multiple of P·D and a bit pulse when it is a multiple of 16·P·D, across exhaustive divisor sweeps of 0 to 31 under both prescaler settings.

// File: rtl/uart_rate_pkg.sv
// Package uart_rate_pkg
// Purpose : shared constants and the prescaler mode encoding for the
//           UART sampling-rate generator.
// Assumes : nothing; pure declarations.
package uart_rate_pkg;

    // Default geometry of the generator
    localparam int DEF_DIV_W      = 16;
    localparam int DEF_BYTE_W     = 8;
    localparam int DEF_SEL_W      = 2;
    localparam int DEF_PRE_RATIO  = 4;
    localparam int DEF_OVERSAMPLE = 16;
    localparam int DEF_RESET_DIV  = 1;
    localparam int DEF_MODE_BIT   = 7;

    // Prescaler selection held in the mode register
    typedef enum logic {
        PRE_PASS = 1'b0,   // every reference cycle counts
        PRE_SLOW = 1'b1    // one reference cycle in PRE_RATIO counts
    } pre_mode_e;

endpackage

// File: rtl/rate_div_regs.sv
// Module rate_div_regs
// Purpose : holds the divisor byte lanes and the prescaler mode bit and
//           raises a one-cycle restart after any write that changes them.
//           Outputs a sanitised divisor in which zero reads as one.
// Assumes : DIV_W is a whole number of BYTE_W lanes; select codes
//           0..DIV_BYTES-1 address lanes, DIV_BYTES addresses the mode
//           register and every higher code is unused.
module rate_div_regs
    import uart_rate_pkg::*;
#(
    parameter int DIV_W     = DEF_DIV_W,
    parameter int BYTE_W    = DEF_BYTE_W,
    parameter int SEL_W     = DEF_SEL_W,
    parameter int RESET_DIV = DEF_RESET_DIV,
    parameter int MODE_BIT  = DEF_MODE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_o,
    output pre_mode_e         mode_o,
    output logic              restart_o
);

    localparam int               DIV_BYTES = DIV_W / BYTE_W;
    localparam logic [SEL_W-1:0] SEL_MODE  = SEL_W'(DIV_BYTES);
    localparam logic [DIV_W-1:0] RST_VEC   = DIV_W'(RESET_DIV);

    logic [DIV_W-1:0] div_raw;
    pre_mode_e        mode_q;
    logic             restart_q;
    logic             hit_any;

    // One register per divisor byte lane, written when its select matches
    for (genvar g = 0; g < DIV_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        // Lane storage: reset value comes from RESET_DIV
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= RST_VEC[g*BYTE_W +: BYTE_W];
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                lane_q <= wr_data;
            end
        end

        assign div_raw[g*BYTE_W +: BYTE_W] = lane_q;
    end

    // Mode register: only MODE_BIT of the data is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PRE_PASS;
        end else if (wr_en && (wr_sel == SEL_MODE)) begin
            mode_q <= wr_data[MODE_BIT] ? PRE_SLOW : PRE_PASS;
        end
    end

    // A write to any live register requests a restart
    always_comb begin
        hit_any = wr_en && (wr_sel <= SEL_MODE);
    end

    // Restart request is registered so the counter loads the new value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= hit_any;
        end
    end

    // Zero divisor is replaced by one so the output never stalls
    always_comb begin
        div_o = (div_raw == '0) ? DIV_W'(1) : div_raw;
    end

    assign mode_o    = mode_q;
    assign restart_o = restart_q;

    // R2: a write on an unused select leaves every register untouched
    p_sel_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel > SEL_MODE)) |=> ($stable(div_raw) && $stable(mode_q) && !restart_q));

endmodule

// File: rtl/rate_prescaler.sv
// Module rate_prescaler
// Purpose : produces the count-enable tick for the divisor counter,
//           either every cycle or once every PRE_RATIO cycles.
// Assumes : PRE_RATIO >= 2; clear_i restarts the phase at zero.
module rate_prescaler
    import uart_rate_pkg::*;
#(
    parameter int PRE_RATIO = DEF_PRE_RATIO
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear_i,
    input  pre_mode_e mode_i,
    output logic      tick_o
);

    localparam int            PW   = (PRE_RATIO > 2) ? $clog2(PRE_RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_RATIO - 1);

    logic [PW-1:0] phase_q;

    // Phase counter runs only in the slow mode and wraps at PRE_RATIO
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || (mode_i == PRE_PASS)) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    // Tick on every cycle, or on the last phase of each slow group
    always_comb begin
        tick_o = (mode_i == PRE_PASS) ? 1'b1 : (phase_q == LAST);
    end

    // R4: in the slow mode two ticks are never adjacent
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (mode_i == PRE_SLOW) && !clear_i) |=> (!tick_o || (mode_i == PRE_PASS)));

endmodule

// File: rtl/rate_down_counter.sv
// Module rate_down_counter
// Purpose : free-running down-counter over prescaler ticks; reloads from
//           the divisor and pulses fire_o for one cycle at each reload.
// Assumes : div_i is never zero; restart_i loads div_i-1 and
//           suppresses the pulse on that edge.
module rate_down_counter
    import uart_rate_pkg::*;
#(
    parameter int DIV_W     = DEF_DIV_W,
    parameter int RESET_DIV = DEF_RESET_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             fire_o,
    output logic             reload_o
);

    localparam logic [DIV_W-1:0] RST_CNT = DIV_W'(((RESET_DIV < 1) ? 1 : RESET_DIV) - 1);

    logic [DIV_W-1:0] cnt_q;
    logic             samp_q;
    logic             reload;

    // Reload is due when a tick meets an expired count
    always_comb begin
        reload = tick_i && (cnt_q == '0);
    end

    // Count down on ticks; restart overrides everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
        end else if (restart_i) begin
            cnt_q <= div_i - DIV_W'(1);
        end else if (reload) begin
            cnt_q <= div_i - DIV_W'(1);
        end else if (tick_i) begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    // Registered one-cycle output pulse at every reload
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            samp_q <= 1'b0;
        end else begin
            samp_q <= reload;
        end
    end

    assign fire_o   = samp_q;
    assign reload_o = reload && !restart_i;

    // R3: outside a restart the count stays below the divisor
    p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |-> (cnt_q < div_i));

    // R7: a restart leaves the output low on the next cycle
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !samp_q);

    // R8: with a divisor above one the pulse is a single cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_q && (div_i != DIV_W'(1))) |=> !samp_q);

endmodule

// File: rtl/rate_bit_divider.sv
// Module rate_bit_divider
// Purpose : counts sampling reloads and pulses bit_o in the same cycle as
//           every OVERSAMPLE-th sampling pulse.
// Assumes : reload_i is the pre-register reload event of the divisor
//           counter, so the registered outputs line up.
module rate_bit_divider
    import uart_rate_pkg::*;
#(
    parameter int OVERSAMPLE = DEF_OVERSAMPLE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic reload_i,
    output logic bit_o
);

    localparam int            OW   = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [OW-1:0] LAST = OW'(OVERSAMPLE - 1);

    logic [OW-1:0] sub_q;
    logic          bit_q;

    // Sub-bit counter advances once per sampling reload
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sub_q <= '0;
        end else if (reload_i) begin
            sub_q <= (sub_q == LAST) ? '0 : sub_q + OW'(1);
        end
    end

    // Bit pulse on the last sub-bit reload
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= reload_i && (sub_q == LAST);
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/uart_rate_gen.sv
// Module uart_rate_gen
// Purpose : top of the UART sampling-rate generator. Joins the register
//           bank, prescaler, divisor counter and bit divider into one
//           enable pair at 16x and 1x the bit rate.
// Assumes : wr_en is a single-cycle strobe per write; all logic runs in
//           the reference clock domain with a synchronous active-low reset.
module uart_rate_gen
    import uart_rate_pkg::*;
#(
    parameter int DIV_W      = DEF_DIV_W,
    parameter int BYTE_W     = DEF_BYTE_W,
    parameter int SEL_W      = DEF_SEL_W,
    parameter int PRE_RATIO  = DEF_PRE_RATIO,
    parameter int OVERSAMPLE = DEF_OVERSAMPLE,
    parameter int RESET_DIV  = DEF_RESET_DIV,
    parameter int MODE_BIT   = DEF_MODE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              samp_en,
    output logic              bit_en
);

    logic [DIV_W-1:0] div_eff;
    pre_mode_e        pre_mode;
    logic             restart;
    logic             tick;
    logic             reload;

    rate_div_regs #(
        .DIV_W     (DIV_W),
        .BYTE_W    (BYTE_W),
        .SEL_W     (SEL_W),
        .RESET_DIV (RESET_DIV),
        .MODE_BIT  (MODE_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .div_o     (div_eff),
        .mode_o    (pre_mode),
        .restart_o (restart)
    );

    rate_prescaler #(
        .PRE_RATIO (PRE_RATIO)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart),
        .mode_i  (pre_mode),
        .tick_o  (tick)
    );

    rate_down_counter #(
        .DIV_W     (DIV_W),
        .RESET_DIV (RESET_DIV)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_i    (tick),
        .div_i     (div_eff),
        .fire_o    (samp_en),
        .reload_o  (reload)
    );

    rate_bit_divider #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (restart),
        .reload_i (reload),
        .bit_o    (bit_en)
    );

    // R6: the bit pulse only appears together with a sampling pulse
    p_bit_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> samp_en);

    // R1: reset holds both enables low on the following cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!samp_en && !bit_en));

endmodule

// File: tb/test_uart_rate_gen.sv
// Bench test_uart_rate_gen
// Purpose : arithmetic scoreboard for the rate generator. A model counts
//           edges since the last restart and expects pulses at multiples of
//           the period; sweeps cover divisors 0..31 under both prescalers.
module test_uart_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       samp_en;
    logic       bit_en;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    string cur_req = "R1";

    // Model state
    logic [7:0] m_lo, m_hi;
    bit         m_slow;
    bit         m_pend;
    int         m_k;

    uart_rate_gen i_uart_rate_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .samp_en (samp_en),
        .bit_en  (bit_en)
    );

    always #2 clk = ~clk;

    // Model: edges since restart and the configuration it runs on
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 8'd1; m_hi = 8'd0; m_slow = 1'b0; m_pend = 1'b0; m_k = 0;
        end else begin
            if (m_pend) m_k = 0;
            else        m_k = m_k + 1;
            m_pend = wr_en && (wr_sel != 2'd3);
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_lo = wr_data;
                    2'd1: m_hi = wr_data;
                    2'd2: m_slow = wr_data[7];
                    default: ;
                endcase
            end
        end
    end

    function automatic int period();
        int d;
        d = {m_hi, m_lo};
        if (d == 0) d = 1;
        return (m_slow ? 4 : 1) * d;
    endfunction

    // Compare both outputs half a cycle after each edge
    always @(negedge clk) begin
        if (!finished && !m_pend) begin
            bit    es, eb;
            string tag;
            int    p;
            p  = period();
            es = (m_k > 0) && (m_k % p == 0);
            eb = (m_k > 0) && (m_k % (16 * p) == 0);
            if (!rst_n) tag = "R1";
            else if (m_k == 0) tag = "R7";
            else tag = cur_req;
            checks++;
            if (samp_en !== es) begin
                errors++;
                $display("FAIL %s samp_en k=%0d period=%0d actual=%b expected=%b", tag, m_k, p, samp_en, es);
            end
            checks++;
            if (bit_en !== eb) begin
                errors++;
                $display("FAIL R6 bit_en k=%0d period=%0d actual=%b expected=%b", m_k, p, bit_en, eb);
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state and default rate
        cur_req = "R1";
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(40);

        // R3 / R4 / R5 exhaustive sweep; mode data also exercises R2 ignored bits
        for (int mode = 0; mode < 2; mode++) begin
            wr(2'd2, (mode != 0) ? 8'h80 : 8'h7F);
            for (int d = 0; d < 32; d++) begin
                wr(2'd1, 8'h00);
                wr(2'd0, 8'(d));
                cur_req = (d == 0) ? "R5" : ((mode != 0) ? "R4" : "R3");
                wait_cyc(16 * ((mode != 0) ? 4 : 1) * ((d == 0) ? 1 : d) + 3);
            end
        end

        // R2: unused select changes nothing mid-run
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd5);
        cur_req = "R2";
        wait_cyc(37);
        wr(2'd3, 8'hFF);
        wait_cyc(200);

        // R9: full 16-bit divisor, including a zero low byte
        cur_req = "R9";
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h02);
        wait_cyc(258 * 3 + 5);
        wr(2'd0, 8'h00);
        wait_cyc(256 * 3 + 5);

        // R7: restart at every phase, including the reload edge
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd3);
        cur_req = "R7";
        for (int j = 0; j < 6; j++) begin
            wait_cyc(j + 1);
            wr(2'd0, 8'd3);
        end
        wait_cyc(60);
        wr(2'd2, 8'h80);
        for (int j = 0; j < 8; j++) begin
            wait_cyc(j + 1);
            wr(2'd2, 8'h80);
        end
        cur_req = "R8";
        wait_cyc(250);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule